// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

A purely combinational 64-bit adder/subtractor whose carry chain can be split into independent lanes. A two-bit size control selects one of four packings: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes, or a single 64-bit word. Within each lane the block adds or subtracts, treating the operands as signed or unsigned two's-complement numbers as selected.

Each lane detects its own overflow. With saturation enabled, an overflowing lane is clamped to the nearest value it can represent. With saturation disabled, the lane wraps modulo its width. A per-byte overflow vector reports which lanes overflowed, with every byte of a lane carrying that lane's flag. It is meant for media datapaths where audio clipping or pixel saturation must happen in the same cycle as the arithmetic.

Top module: `simd_sat_adder`

## Requirements
- R1: `lane_size_i` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives one 64-bit lane. Lane k of width w occupies bits [k*w+w-1 : k*w]. No carry or borrow passes from one lane into the next.
- R2: With `sub_i`=0 and `sat_en_i`=0, each lane of `sum_o` equals (a+b) mod 2^w. With all inputs zero, the outputs are zero.
- R3: With `sub_i`=1 and `sat_en_i`=0, each lane of `sum_o` equals (a-b) mod 2^w. The lane adds the inverted b with a carry-in of one.
- R4: Signed overflow, with `signed_i`=1, occurs in two cases. For an add, it occurs when both operands have the same sign and the true sum has the opposite sign. For a subtract, it occurs when the operands differ in sign and the result's sign differs from a's sign. An add of operands with opposite signs never overflows.
- R5: Unsigned overflow, with `signed_i`=0, is a carry out of the lane's top bit for an add. For a subtract, it is a borrow, which occurs when a < b.
- R6: Signed saturation: when `sat_en_i`=1 and a signed lane overflows, the lane takes its most positive value (0 followed by all ones) on positive overflow. It takes its most negative value (1 followed by all zeros) on negative overflow.
- R7: Unsigned saturation: when `sat_en_i`=1 and an unsigned lane overflows, an add clamps the lane to all ones and a subtract clamps it to zero.
- R8: Bit j of `ovf_o` is 1 exactly when the lane containing byte j (bits 8j+7..8j) overflowed. All bytes of one lane carry the same flag. The flag is reported whether or not saturation is enabled.
- R9: A lane that does not overflow gives the same result whether `sat_en_i` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | Packed operand A (minuend for subtract) |
| b_i | input | 64 | Packed operand B (subtrahend for subtract) |
| lane_size_i | input | 2 | Lane width select (00/01/10/11 = 8/16/32/64 bits) |
| sub_i | input | 1 | 1 = subtract B from A, 0 = add |
| signed_i | input | 1 | 1 = signed lanes, 0 = unsigned lanes |
| sat_en_i | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| sum_o | output | 64 | Packed per-lane result |
| ovf_o | output | 8 | Per-byte overflow flag, replicated across each lane |

## Verification
The bench looks for carries that leak across lane boundaries. It uses an all-ones byte next to a zero byte, where 8-bit lanes must wrap while 16-bit lanes must carry. A design that cut the chain at the wrong place would corrupt the neighbouring lane or report an overflow in the wrong byte. The bench drives both signed clamp directions and the unsigned floor and ceiling. A design that clamped from the result's sign instead of the operand's sign would pick the wrong extreme, and one that confused borrow with carry on subtract would clamp lanes that are in range. Random operands in every size and mode are compared against a wide-integer model. This catches flag replication, and any change to lanes that do not overflow, in all four packings.

// File: rtl/simd_sat_pkg.sv
package simd_sat_pkg;

  localparam int BYTE_W = 8;
  localparam int NBYTES = 8;
  localparam int DATA_W = BYTE_W * NBYTES;
  localparam int IDX_W  = $clog2(NBYTES);

  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_B16 = 2'b01,
    LANE_B32 = 2'b10,
    LANE_B64 = 2'b11
  } lane_size_e;

  // Number of bytes in one lane for a given size code.
  function automatic int lane_span(lane_size_e s);
    return 1 << int'(s);
  endfunction

  // Overflow of a lane judged at its top byte from the two top carries.
  function automatic logic lane_overflow(logic is_signed, logic is_sub,
                                         logic c_into_msb, logic c_out);
    if (is_signed) return c_into_msb ^ c_out;
    else if (is_sub) return ~c_out;
    else return c_out;
  endfunction

  // Clamp value for one byte of an overflowing lane.
  function automatic logic [BYTE_W-1:0] clamp_byte(logic is_signed, logic is_sub,
                                                   logic is_top, logic a_neg);
    logic [BYTE_W-1:0] v;
    if (!is_signed) begin
      v = is_sub ? '0 : '1;
    end else if (!a_neg) begin
      v = '1;
      if (is_top) v[BYTE_W-1] = 1'b0;
    end else begin
      v = '0;
      if (is_top) v[BYTE_W-1] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/simd_lane_ctrl.sv
module simd_lane_ctrl
  import simd_sat_pkg::*;
(
  input  lane_size_e                     size_i,
  output logic [NBYTES-1:0]              start_o,
  output logic [NBYTES-1:0][IDX_W-1:0]   top_idx_o
);

  always_comb begin
    int span;
    span = lane_span(size_i);
    for (int i = 0; i < NBYTES; i++) begin
      start_o[i]   = ((i % span) == 0);
      top_idx_o[i] = IDX_W'(i - (i % span) + span - 1);
    end
  end

endmodule

// File: rtl/simd_byte_slice.sv
module simd_byte_slice
  import simd_sat_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  output logic [BYTE_W-1:0] sum_o,
  output logic              c_msb_o,
  output logic              cout_o
);

  logic [BYTE_W-1:0] b_eff;
  logic [BYTE_W-1:0] low;
  logic [1:0]        top;

  always_comb begin
    b_eff   = b_i ^ {BYTE_W{sub_i}};
    low     = {1'b0, a_i[BYTE_W-2:0]} + {1'b0, b_eff[BYTE_W-2:0]} + BYTE_W'(cin_i);
    top     = {1'b0, a_i[BYTE_W-1]} + {1'b0, b_eff[BYTE_W-1]} + {1'b0, low[BYTE_W-1]};
    sum_o   = {top[0], low[BYTE_W-2:0]};
    c_msb_o = low[BYTE_W-1];
    cout_o  = top[1];
  end

endmodule

// File: rtl/simd_lane_sat.sv
module simd_lane_sat
  import simd_sat_pkg::*;
(
  input  logic [BYTE_W-1:0] raw_i,
  input  logic              lane_ovf_i,
  input  logic              is_top_i,
  input  logic              a_neg_i,
  input  logic              signed_i,
  input  logic              sub_i,
  input  logic              sat_en_i,
  output logic [BYTE_W-1:0] res_o
);

  always_comb begin
    if (sat_en_i && lane_ovf_i)
      res_o = clamp_byte(signed_i, sub_i, is_top_i, a_neg_i);
    else
      res_o = raw_i;
  end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
  import simd_sat_pkg::*;
(
  input  logic [63:0] a_i,
  input  logic [63:0] b_i,
  input  logic [1:0]  lane_size_i,
  input  logic        sub_i,
  input  logic        signed_i,
  input  logic        sat_en_i,
  output logic [63:0] sum_o,
  output logic [7:0]  ovf_o
);

  logic [NBYTES-1:0]             lane_start;
  logic [NBYTES-1:0][IDX_W-1:0]  lane_top;
  logic [NBYTES-1:0]             slice_cin;
  logic [NBYTES-1:0]             slice_cout;
  logic [NBYTES-1:0]             slice_cmsb;
  logic [NBYTES-1:0]             byte_ovf;
  logic [NBYTES-1:0]             a_msb;
  logic [NBYTES-1:0][BYTE_W-1:0] raw_sum;

  simd_lane_ctrl u_ctrl (
    .size_i    (lane_size_e'(lane_size_i)),
    .start_o   (lane_start),
    .top_idx_o (lane_top)
  );

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    if (i == 0) begin : g_first
      assign slice_cin[i] = sub_i;
    end else begin : g_chain
      assign slice_cin[i] = lane_start[i] ? sub_i : slice_cout[i-1];
    end

    assign a_msb[i] = a_i[i*BYTE_W + BYTE_W-1];

    simd_byte_slice u_slice (
      .a_i     (a_i[i*BYTE_W +: BYTE_W]),
      .b_i     (b_i[i*BYTE_W +: BYTE_W]),
      .sub_i   (sub_i),
      .cin_i   (slice_cin[i]),
      .sum_o   (raw_sum[i]),
      .c_msb_o (slice_cmsb[i]),
      .cout_o  (slice_cout[i])
    );

    assign byte_ovf[i] = lane_overflow(signed_i, sub_i, slice_cmsb[i], slice_cout[i]);
    assign ovf_o[i]    = byte_ovf[lane_top[i]];

    simd_lane_sat u_sat (
      .raw_i      (raw_sum[i]),
      .lane_ovf_i (ovf_o[i]),
      .is_top_i   (lane_top[i] == IDX_W'(i)),
      .a_neg_i    (a_msb[lane_top[i]]),
      .signed_i   (signed_i),
      .sub_i      (sub_i),
      .sat_en_i   (sat_en_i),
      .res_o      (sum_o[i*BYTE_W +: BYTE_W])
    );
  end

endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk
  import simd_sat_pkg::*;
(
  input logic [63:0]       a_i,
  input logic [63:0]       b_i,
  input logic [1:0]        lane_size_i,
  input logic              sub_i,
  input logic              signed_i,
  input logic              sat_en_i,
  input logic [63:0]       sum_o,
  input logic [7:0]        ovf_o,
  input logic [NBYTES-1:0] lane_start,
  input logic [NBYTES-1:0] slice_cin
);

  always_comb begin
    for (int i = 0; i < NBYTES; i++) begin
      // R1: a lane's first byte takes the mode carry-in, never the neighbour's carry
      if (lane_start[i])
        a_r1_carry_cut: assert (slice_cin[i] == sub_i);
      // R8: bytes inside one lane report the same flag
      if (i > 0 && !lane_start[i])
        a_r8_ovf_replicated: assert (ovf_o[i] == ovf_o[i-1]);
    end
    // R2, R3: full-width wrap agrees with plain integer arithmetic
    if (lane_size_i == 2'b11 && !sat_en_i)
      a_r2_wrap64: assert (sum_o == (sub_i ? a_i - b_i : a_i + b_i));
    // R4: mixed-sign signed add never overflows
    if (lane_size_i == 2'b11 && signed_i && !sub_i && (a_i[63] != b_i[63]))
      a_r4_mixed_sign_add: assert (ovf_o == 8'h00);
    // R7: unsigned saturating subtract floors at zero
    if (lane_size_i == 2'b00 && !signed_i && sub_i && sat_en_i && (a_i[7:0] < b_i[7:0]))
      a_r7_unsigned_floor: assert (sum_o[7:0] == 8'h00 && ovf_o[0]);
  end

endmodule

bind simd_sat_adder simd_sat_adder_chk u_chk (
  .a_i         (a_i),
  .b_i         (b_i),
  .lane_size_i (lane_size_i),
  .sub_i       (sub_i),
  .signed_i    (signed_i),
  .sat_en_i    (sat_en_i),
  .sum_o       (sum_o),
  .ovf_o       (ovf_o),
  .lane_start  (lane_start),
  .slice_cin   (slice_cin)
);

// File: tb/simd_sat_adder_test.sv
module simd_sat_adder_test;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic [1:0]  sz;
    logic        sub;
    logic        sgn;
    logic        sat;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{64'h7F7F_8080_FFFF_0001, 64'h0101_FFFF_0101_0001, 2'd0, 1'b0, 1'b1, 1'b1},
    '{64'h7F7F_8080_FFFF_0001, 64'h0101_FFFF_0101_0001, 2'd0, 1'b0, 1'b0, 1'b0},
    '{64'h0010_8000_7FFF_1234, 64'h0020_0001_FFFF_4321, 2'd1, 1'b1, 1'b1, 1'b1},
    '{64'h0010_8000_7FFF_1234, 64'h0020_0001_FFFF_4321, 2'd1, 1'b1, 1'b0, 1'b1},
    '{64'h8000_0000_7FFF_FFFF, 64'h8000_0000_0000_0001, 2'd2, 1'b0, 1'b1, 1'b1},
    '{64'hFFFF_FFFF_0000_0005, 64'h0000_0001_0000_0009, 2'd2, 1'b0, 1'b0, 1'b1},
    '{64'h0000_0000_0000_0005, 64'h0000_0000_0000_0009, 2'd2, 1'b1, 1'b0, 1'b0},
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 1'b0, 1'b1, 1'b1},
    '{64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'd3, 1'b1, 1'b1, 1'b1},
    '{64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 2'd3, 1'b1, 1'b0, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic [63:0] a, b, sum;
  logic [1:0]  sz;
  logic        sub, sgn, sat;
  logic [7:0]  ovf;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  simd_sat_adder uut (
    .a_i(a), .b_i(b), .lane_size_i(sz), .sub_i(sub),
    .signed_i(sgn), .sat_en_i(sat), .sum_o(sum), .ovf_o(ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: all requirements, actual %0d cycles, expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Independent wide-integer reference for one operation.
  function automatic void model(input logic [63:0] ma, mb, input logic [1:0] msz,
                                input logic msub, msgn, msat,
                                output logic [63:0] es, output logic [7:0] eo);
    int lw, nl, bpl;
    lw  = 8 << msz;
    nl  = 64 / lw;
    bpl = lw / 8;
    es  = '0;
    eo  = '0;
    for (int l = 0; l < nl; l++) begin
      logic [65:0] mask, ea, eb, r, res;
      logic signed [65:0] rs, hi, lo;
      logic ov;
      mask = (66'd1 << lw) - 66'd1;
      ea = ({2'b00, ma} >> (l * lw)) & mask;
      eb = ({2'b00, mb} >> (l * lw)) & mask;
      if (msgn && ea[lw-1]) ea = ea | ~mask;
      if (msgn && eb[lw-1]) eb = eb | ~mask;
      r  = msub ? ea - eb : ea + eb;
      rs = r;
      hi = (66'sd1 <<< (lw - 1)) - 66'sd1;
      lo = -hi - 66'sd1;
      if (msgn) ov = (rs > hi) || (rs < lo);
      else      ov = msub ? (ea < eb) : (r > mask);
      res = r;
      if (ov && msat) begin
        if (!msgn)        res = msub ? 66'd0 : mask;
        else if (rs < 0)  res = lo;
        else              res = hi;
      end
      es = es | 64'((res & mask) << (l * lw));
      for (int k = 0; k < bpl; k++) eo[l * bpl + k] = ov;
    end
  endfunction

  task automatic check(input string req, input logic [63:0] es, input logic [7:0] eo);
    checks++;
    if (sum !== es || ovf !== eo) begin
      errors++;
      $display("FAIL %s: actual sum=%h ovf=%h expected sum=%h ovf=%h", req, sum, ovf, es, eo);
    end
  endtask

  task automatic apply(input logic [63:0] ta, tb, input logic [1:0] tsz,
                       input logic tsub, tsgn, tsat);
    @(posedge clk);
    a = ta; b = tb; sz = tsz; sub = tsub; sgn = tsgn; sat = tsat;
    @(negedge clk);
  endtask

  initial begin
    logic [63:0] es;
    logic [7:0]  eo;
    rst_n = 1'b0;
    a = '0; b = '0; sz = '0; sub = 1'b0; sgn = 1'b0; sat = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 idle zero", 64'h0, 8'h00);
    rst_n = 1'b1;

    // Table walk against the model
    for (int v = 0; v < NVEC; v++) begin
      apply(VECS[v].a, VECS[v].b, VECS[v].sz, VECS[v].sub, VECS[v].sgn, VECS[v].sat);
      model(VECS[v].a, VECS[v].b, VECS[v].sz, VECS[v].sub, VECS[v].sgn, VECS[v].sat, es, eo);
      check("R1 R2 R3 R4 R5 R6 R7 R8 table", es, eo);
    end

    // Directed corner cases with hand-derived results
    apply(64'h00FF00FF00FF00FF, 64'h0001000100010001, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R1 R5 byte lanes wrap, no carry crosses", 64'h0, 8'h55);
    apply(64'h00FF00FF00FF00FF, 64'h0001000100010001, 2'd1, 1'b0, 1'b0, 1'b0);
    check("R1 halfword lanes carry inside lane", 64'h0100010001000100, 8'h00);
    apply(64'h7F80000000000010, 64'h01FF000000000020, 2'd0, 1'b0, 1'b1, 1'b1);
    check("R4 R6 R9 signed byte clamp both ways", 64'h7F80000000000030, 8'hC0);
    apply(64'h0000000000000905, 64'h0000000000000509, 2'd0, 1'b1, 1'b0, 1'b1);
    check("R3 R5 R7 unsigned byte floor", 64'h0000000000000400, 8'h01);
    apply(64'h0000000000008000, 64'h0000000000000001, 2'd1, 1'b1, 1'b1, 1'b1);
    check("R6 R8 signed halfword negative clamp", 64'h0000000000008000, 8'h03);
    apply(64'hFFFFFFFFFFFFFFFF, 64'h0000000000000001, 2'd3, 1'b0, 1'b0, 1'b1);
    check("R7 R8 unsigned 64-bit ceiling", 64'hFFFFFFFFFFFFFFFF, 8'hFF);
    apply(64'h000000007FFFFFFF, 64'h0000000000000001, 2'd2, 1'b0, 1'b1, 1'b0);
    check("R2 R4 R8 signed word wrap flagged", 64'h0000000080000000, 8'h0F);
    apply(64'h0000000000000000, 64'h0000000000000001, 2'd0, 1'b1, 1'b0, 1'b0);
    check("R3 unsigned byte borrow wraps", 64'h00000000000000FF, 8'h01);
    apply(64'h8000000000000000, 64'h8000000000000000, 2'd2, 1'b0, 1'b1, 1'b1);
    check("R6 signed word negative clamp", 64'h8000000000000000, 8'hF0);
    apply(64'h7FFFFFFFFFFFFFFF, 64'h8000000000000000, 2'd3, 1'b0, 1'b1, 1'b1);
    check("R4 mixed sign add no overflow", 64'hFFFFFFFFFFFFFFFF, 8'h00);

    // Random sweep over all sizes and modes
    for (int n = 0; n < 400; n++) begin
      logic [63:0] ra, rb;
      logic [5:0]  m;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      m  = 6'($urandom());
      apply(ra, rb, m[1:0], m[2], m[3], m[4]);
      model(ra, rb, m[1:0], m[2], m[3], m[4], es, eo);
      check("R1 R2 R3 R4 R5 R6 R7 R8 R9 random", es, eo);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule